// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block moves a programmed number of bus cycles between a 32-bit word queue and a parallel command/data bus toward a display controller. Each 32-bit word from the transmit queue is split into narrow bus beats of a programmable width (8 or 16 bits in normal use), taken least-significant first. In read mode, the beats captured from the bus are packed back into 32-bit words in the same order and pushed into a receive queue. A done flag is high whenever nothing is pending, so software can order a read after outstanding writes.

Every bus cycle has three parts, each counted in ticks of an external enable that the clock divider supplies: one setup tick with the strobe inactive, a strobe-active phase of 1 to 16 ticks, and the rest of the cycle. Configuration is captured at start. The controller has five named states. IDLE goes to LAUNCH on a start with a legal rest length. LAUNCH is the setup tick. It waits for the bus gates and for data, then goes to STROBE on a tick. STROBE goes to HOLD when the strobe phase count runs out. HOLD goes back to LAUNCH when its count runs out, or to FINISH after the last cycle. FINISH flushes any partial read word, raises done and returns to IDLE.

Top module: `dbus_write_engine`

## Requirements
- R1: After reset, bus_cs_n, bus_we_n and bus_re_n are high, done is high, and tx_pop and rx_push are low.
- R2: The strobe (bus_we_n in write mode, bus_re_n in read mode) is low for exactly cfg_on_m1+1 ticks in each bus cycle; cfg_on_m1 is 4 bits wide.
- R3: Each bus cycle lasts cfg_on_m1+cfg_rest_m1+2 ticks. The strobe is inactive in the first tick of the cycle, so successive strobe falls are that many ticks apart. cfg_rest_m1 is 6 bits wide.
- R4: A start with cfg_rest_m1 below 2 (rest of cycle shorter than 3 ticks) resets the engine to IDLE: no bus cycle runs, no word is popped and done stays high.
- R5: A transfer runs exactly cfg_cycles_m1+1 bus cycles (18-bit field). done falls on the clock after start and rises after the last cycle.
- R6: bus_dc is the captured cfg_data_sel for the whole transfer (0 marks a command beat, 1 a data beat). bus_dc and bus_dout are stable while the strobe is low.
- R7: Beat k of a word (k counted from 0) carries bits [k*W +: W], where W = cfg_width_m1+1 and the count per word is cfg_picks_m1+1. tx_pop pulses once, after the last pick of each word.
- R8: bus_cs_n is low only while a transfer is active and cs_ctl_n is low. While cs_ctl_n is high no bus cycle starts. In write mode no bus cycle starts while we_ctl_n is high.
- R9: In write mode a cycle that needs the next word waits while tx_valid is low, and tx_pop never pulses while tx_valid is low.
- R10: In read mode (cfg_read=1) only bus_re_n strobes. bus_din is sampled in the last strobe tick and packed least-significant first. rx_push pulses with each full word, and a partial last word is pushed with its upper bits zero.
- R11: All phase lengths are counted in ticks. Strobe edges happen only on clock edges where tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Divided timing enable |
| start | input | 1 | Begin a transfer (taken in IDLE only) |
| cfg_on_m1 | input | 4 | Strobe-active ticks minus one |
| cfg_rest_m1 | input | 6 | Rest-of-cycle ticks minus one |
| cfg_width_m1 | input | 5 | Beat width minus one |
| cfg_picks_m1 | input | 2 | Beats per word minus one |
| cfg_cycles_m1 | input | 18 | Bus cycles minus one |
| cfg_data_sel | input | 1 | 0 command, 1 data |
| cfg_read | input | 1 | 1 selects read mode |
| cs_ctl_n | input | 1 | Chip-select control, active low |
| we_ctl_n | input | 1 | Write gate, active low |
| tx_data | input | 32 | Head word of transmit queue |
| tx_valid | input | 1 | Transmit queue not empty |
| tx_pop | output | 1 | Consume head word |
| rx_data | output | 32 | Packed read word |
| rx_push | output | 1 | rx_data is valid |
| bus_din | input | 16 | Read data from bus |
| bus_dout | output | 16 | Write data to bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Command/data line |
| done | output | 1 | No transfer pending |

## Verification
The bench builds the engine with its default parameters: a 32-bit word, a 16-bit bus, an 18-bit cycle count and the 4-bit and 6-bit phase fields. With these it can reach the extreme phase lengths of 16 and 64 ticks, both the four-beat and the two-beat split of a word, and partial read words. A divide-by-three tick shows that the phase lengths scale with the tick and not with the clock.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_FINISH = 3'd4
    } dbw_state_t;
endpackage

// File: rtl/dbw_phase_timer.sv
// Down counter shared by the strobe phase and the rest-of-cycle phase.
module dbw_phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dbw_beat_counter.sv
// Counts bus cycles of a transfer against the programmed limit.
module dbw_beat_counter #(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] limit,
    output logic             last
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == limit);
endmodule

// File: rtl/dbw_pick_unit.sv
// Selects the current beat out of the head word and packs read beats.
module dbw_pick_unit #(
    parameter int WORD_W = 32,
    parameter int BUS_W  = 16,
    parameter int PW_W   = 5,
    parameter int PC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              advance,
    input  logic [PW_W-1:0]   width_m1,
    input  logic [PC_W-1:0]   picks_m1,
    input  logic [WORD_W-1:0] word,
    input  logic [BUS_W-1:0]  din,
    output logic [BUS_W-1:0]  dout,
    output logic              last_pick,
    output logic              partial,
    output logic [WORD_W-1:0] acc
);
    localparam int SH_W = PC_W + PW_W + 1;

    logic [PC_W-1:0]   pidx;
    logic [SH_W-1:0]   shamt;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] sel;

    assign shamt     = SH_W'(pidx) * (SH_W'(width_m1) + SH_W'(1));
    assign mask      = ~({WORD_W{1'b1}} << (SH_W'(width_m1) + SH_W'(1)));
    assign sel       = (word >> shamt) & mask;
    assign dout      = sel[BUS_W-1:0];
    assign last_pick = (pidx == picks_m1);
    assign partial   = (pidx != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pidx <= '0;
            acc  <= '0;
        end else if (clear) begin
            pidx <= '0;
            acc  <= '0;
        end else begin
            if (capture)
                acc <= acc | ((WORD_W'(din) & mask) << shamt);
            if (advance) begin
                if (last_pick) begin
                    pidx <= '0;
                    acc  <= '0;
                end else begin
                    pidx <= pidx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dbus_write_engine.sv
module dbus_write_engine
    import dbw_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int BUS_W    = 16,
    parameter int ON_W     = 4,
    parameter int REST_W   = 6,
    parameter int LEN_W    = 18,
    parameter int PW_W     = 5,
    parameter int PC_W     = 2,
    parameter int MIN_REST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [ON_W-1:0]   cfg_on_m1,
    input  logic [REST_W-1:0] cfg_rest_m1,
    input  logic [PW_W-1:0]   cfg_width_m1,
    input  logic [PC_W-1:0]   cfg_picks_m1,
    input  logic [LEN_W-1:0]  cfg_cycles_m1,
    input  logic              cfg_data_sel,
    input  logic              cfg_read,
    input  logic              cs_ctl_n,
    input  logic              we_ctl_n,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_push,
    input  logic [BUS_W-1:0]  bus_din,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic              bus_re_n,
    output logic              bus_dc,
    output logic              done
);
    localparam logic [REST_W-1:0] REST_MIN_M1 = REST_W'(MIN_REST - 1);

    dbw_state_t state, nxt;

    logic [ON_W-1:0]   r_on;
    logic [REST_W-1:0] r_rest;
    logic [PW_W-1:0]   r_width;
    logic [PC_W-1:0]   r_picks;
    logic [LEN_W-1:0]  r_cycles;
    logic              r_dc;
    logic              r_read;

    logic rest_ok, launch_ok, accept, cycle_end, strobe_end;
    logic ph_load, ph_dec, ph_zero;
    logic [REST_W-1:0] ph_val;
    logic beat_last, last_pick, partial;
    logic [BUS_W-1:0] pick_dout;

    assign rest_ok    = (cfg_rest_m1 >= REST_MIN_M1);
    assign accept     = (state == ST_IDLE) && start;
    assign launch_ok  = !cs_ctl_n && (r_read || (!we_ctl_n && tx_valid));
    assign strobe_end = (state == ST_STROBE) && tick && ph_zero;
    assign cycle_end  = (state == ST_HOLD) && tick && ph_zero;

    // phase timer control: load strobe length on launch, rest length after strobe
    assign ph_load = ((state == ST_LAUNCH) && tick && launch_ok) || strobe_end;
    assign ph_val  = (state == ST_LAUNCH) ? REST_W'(r_on) : (r_rest - 1'b1);
    assign ph_dec  = tick && ((state == ST_STROBE) || (state == ST_HOLD));

    dbw_phase_timer #(.CW(REST_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .dec      (ph_dec),
        .zero     (ph_zero)
    );

    dbw_beat_counter #(.LEN_W(LEN_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (cycle_end && !beat_last),
        .limit (r_cycles),
        .last  (beat_last)
    );

    dbw_pick_unit #(
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W),
        .PW_W   (PW_W),
        .PC_W   (PC_W)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (strobe_end && r_read),
        .advance   (cycle_end),
        .width_m1  (r_width),
        .picks_m1  (r_picks),
        .word      (tx_data),
        .din       (bus_din),
        .dout      (pick_dout),
        .last_pick (last_pick),
        .partial   (partial),
        .acc       (rx_data)
    );

    // state register, captured configuration and done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            r_on     <= '0;
            r_rest   <= '0;
            r_width  <= '0;
            r_picks  <= '0;
            r_cycles <= '0;
            r_dc     <= 1'b0;
            r_read   <= 1'b0;
            done     <= 1'b1;
        end else begin
            state <= nxt;
            if (accept) begin
                if (rest_ok) begin
                    r_on     <= cfg_on_m1;
                    r_rest   <= cfg_rest_m1;
                    r_width  <= cfg_width_m1;
                    r_picks  <= cfg_picks_m1;
                    r_cycles <= cfg_cycles_m1;
                    r_dc     <= cfg_data_sel;
                    r_read   <= cfg_read;
                    done     <= 1'b0;
                end else begin
                    done     <= 1'b1;
                end
            end else if (state == ST_FINISH) begin
                done <= 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start && rest_ok) nxt = ST_LAUNCH;
            ST_LAUNCH: if (tick && launch_ok) nxt = ST_STROBE;
            ST_STROBE: if (tick && ph_zero) nxt = ST_HOLD;
            ST_HOLD:   if (tick && ph_zero) nxt = beat_last ? ST_FINISH : ST_LAUNCH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_we_n = 1'b1;
        bus_re_n = 1'b1;
        bus_cs_n = 1'b1;
        bus_dc   = 1'b0;
        bus_dout = '0;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LAUNCH, ST_HOLD, ST_FINISH: begin
                bus_cs_n = cs_ctl_n;
                bus_dc   = r_dc;
                bus_dout = r_read ? '0 : pick_dout;
            end
            ST_STROBE: begin
                bus_cs_n = cs_ctl_n;
                bus_dc   = r_dc;
                bus_dout = r_read ? '0 : pick_dout;
                bus_we_n = r_read;
                bus_re_n = !r_read;
            end
            default: ;
        endcase
        if (cycle_end && last_pick) begin
            tx_pop  = !r_read;
            rx_push = r_read;
        end
        if (state == ST_FINISH && r_read && partial)
            rx_push = 1'b1;
    end
endmodule

// File: rtl/dbw_checker.sv
module dbw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        tx_valid,
    input logic        tx_pop,
    input logic [15:0] bus_dout,
    input logic        bus_cs_n,
    input logic        bus_we_n,
    input logic        bus_re_n,
    input logic        bus_dc,
    input logic        done
);
    // R10: never both strobes at once
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_re_n));

    // R8: a strobe only while chip select is asserted
    a_r8_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_re_n) |-> !bus_cs_n);

    // R9: no pop from an empty queue
    a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    // R5: done is low while a strobe is active
    a_r5_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_re_n) |-> !done);

    // R6: command/data line and write data hold through the strobe
    a_r6_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_dc) && $stable(bus_dout)));

    // R11: strobes move only on tick edges
    a_r11_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(bus_we_n) && $stable(bus_re_n)));
endmodule

bind dbus_write_engine dbw_checker u_dbw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .tx_valid (tx_valid),
    .tx_pop   (tx_pop),
    .bus_dout (bus_dout),
    .bus_cs_n (bus_cs_n),
    .bus_we_n (bus_we_n),
    .bus_re_n (bus_re_n),
    .bus_dc   (bus_dc),
    .done     (done)
);

// File: tb/dbus_write_engine_test.sv
module dbus_write_engine_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, tick, start;
    logic [3:0]  cfg_on_m1;
    logic [5:0]  cfg_rest_m1;
    logic [4:0]  cfg_width_m1;
    logic [1:0]  cfg_picks_m1;
    logic [17:0] cfg_cycles_m1;
    logic        cfg_data_sel, cfg_read, cs_ctl_n, we_ctl_n;
    logic [31:0] tx_data, rx_data;
    logic        tx_valid, tx_pop, rx_push;
    logic [15:0] bus_din, bus_dout;
    logic        bus_cs_n, bus_we_n, bus_re_n, bus_dc, done;

    dbus_write_engine uut (.*);

    typedef struct packed {
        logic [3:0] on_m1;
        logic [5:0] rest_m1;
        logic       mode16;
        logic [7:0] cyc_m1;
        logic       dc;
        logic [3:0] div;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{on_m1: 4'd0,  rest_m1: 6'd2,  mode16: 1'b0, cyc_m1: 8'd7, dc: 1'b1, div: 4'd1},
        '{on_m1: 4'd3,  rest_m1: 6'd5,  mode16: 1'b1, cyc_m1: 8'd4, dc: 1'b0, div: 4'd1},
        '{on_m1: 4'd15, rest_m1: 6'd63, mode16: 1'b1, cyc_m1: 8'd1, dc: 1'b1, div: 4'd1},
        '{on_m1: 4'd1,  rest_m1: 6'd3,  mode16: 1'b0, cyc_m1: 8'd5, dc: 1'b0, div: 4'd3}
    };

    int checks = 0, fails = 0, cyc = 0;
    int div = 1, tdiv = 0;
    int tx_idx = 0, tx_avail = 0;
    int rd_cnt = 0;

    function automatic logic [31:0] word_at(int k);
        return 32'h8E1F25C4 ^ (32'(k) * 32'h13579BDF);
    endfunction

    assign tx_valid = (tx_idx < tx_avail);
    assign tx_data  = word_at(tx_idx);
    assign tick     = (tdiv == 0);
    assign bus_din  = 16'hC3A0 + 16'(rd_cnt) * 16'h0111;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tdiv <= (tdiv + 1 >= div) ? 0 : tdiv + 1;
        if (rst_n && tx_pop) tx_idx <= tx_idx + 1;
    end

    // bus monitor, sampled between edges
    int n_str = 0, n_push = 0, cur_w = 0, done_low = 0, cs_bad = 0, we_falls = 0;
    bit str_prev = 1'b0, rd_prev = 1'b0;
    int          fall_t  [64];
    int          width_v [64];
    logic [15:0] beat_v  [64];
    logic        beat_dc [64];
    logic [31:0] rx_v    [16];

    always @(negedge clk) begin
        automatic bit s = !bus_we_n || !bus_re_n;
        if (s && !str_prev) begin
            if (n_str < 64) begin
                fall_t[n_str]  = cyc;
                beat_v[n_str]  = bus_dout;
                beat_dc[n_str] = bus_dc;
            end
            if (!bus_we_n) we_falls++;
            rd_prev = !bus_re_n;
            cur_w = 1;
        end else if (s) begin
            cur_w++;
        end
        if (s && bus_cs_n) cs_bad++;
        if (!s && str_prev) begin
            if (n_str < 64) width_v[n_str] = cur_w;
            n_str++;
            if (rd_prev) rd_cnt++;
        end
        str_prev = s;
        if (rx_push && rst_n) begin
            if (n_push < 16) rx_v[n_push] = rx_data;
            n_push++;
        end
        if (!done) done_low++;
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_str = 0; n_push = 0; done_low = 0; cs_bad = 0; we_falls = 0;
    endtask

    task automatic go();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done, req, "done timeout", 32'(done), 32'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(int on, int rest, bit m16, int cm1, bit dc, bit rd);
        cfg_on_m1     = 4'(on);
        cfg_rest_m1   = 6'(rest);
        cfg_width_m1  = m16 ? 5'd15 : 5'd7;
        cfg_picks_m1  = m16 ? 2'd1 : 2'd3;
        cfg_cycles_m1 = 18'(cm1);
        cfg_data_sel  = dc;
        cfg_read      = rd;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; cs_ctl_n = 1'b0; we_ctl_n = 1'b0;
        set_cfg(0, 2, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_cs_n && bus_we_n && bus_re_n, "R1", "strobes/cs idle", {bus_cs_n, bus_we_n, bus_re_n}, 3'b111);
        check(done === 1'b1, "R1", "done at reset", 32'(done), 1);
        check(!tx_pop && !rx_push, "R1", "no pop/push", {tx_pop, rx_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of write transfers
        foreach (VECS[v]) begin
            automatic vec_t e = VECS[v];
            automatic int base = tx_idx;
            automatic int w = e.mode16 ? 16 : 8;
            automatic int pk = e.mode16 ? 2 : 4;
            automatic int nb = int'(e.cyc_m1) + 1;
            automatic int dv = int'(e.div);
            automatic int dc_bad = 0, w_bad = 0, p_bad = 0;
            tx_avail = base + 16;
            div = dv;
            set_cfg(int'(e.on_m1), int'(e.rest_m1), e.mode16, int'(e.cyc_m1), e.dc, 1'b0);
            clear_log();
            go();
            wait_done("R5");
            check(n_str == nb, "R5", "beat count", n_str, nb);
            check(done_low > 0, "R5", "done low during transfer", done_low, 1);
            for (int i = 0; i < nb && i < 64; i++) begin
                automatic logic [31:0] wd = word_at(base + i / pk);
                automatic logic [15:0] ex = 16'((wd >> ((i % pk) * w)) & (w == 16 ? 32'hFFFF : 32'hFF));
                check(beat_v[i] == ex, "R7", "beat value", beat_v[i], ex);
                if (beat_dc[i] != e.dc) dc_bad++;
                if (width_v[i] != (int'(e.on_m1) + 1) * dv) w_bad++;
                if (i > 0 && fall_t[i] - fall_t[i-1] != (int'(e.on_m1) + int'(e.rest_m1) + 2) * dv) p_bad++;
            end
            check(dc_bad == 0, "R6", "dc mismatches", dc_bad, 0);
            check(w_bad == 0, dv > 1 ? "R11" : "R2", "strobe width mismatches", w_bad, 0);
            check(p_bad == 0, dv > 1 ? "R11" : "R3", "cycle period mismatches", p_bad, 0);
            check(tx_idx - base == nb / pk, "R7", "pop count", tx_idx - base, nb / pk);
            check(cs_bad == 0, "R8", "cs high during strobe", cs_bad, 0);
        end
        div = 1;

        // R4: illegal rest length
        begin
            automatic int base = tx_idx;
            tx_avail = base + 8;
            set_cfg(0, 1, 0, 3, 1, 0);
            clear_log();
            go();
            repeat (40) @(negedge clk);
            check(n_str == 0, "R4", "strobes after illegal start", n_str, 0);
            check(done_low == 0 && done, "R4", "done stayed high", done_low, 0);
            check(tx_idx == base, "R4", "no pop", tx_idx - base, 0);
        end

        // R8: chip-select control holds off, then releases
        begin
            set_cfg(1, 2, 1, 1, 1, 0);
            cs_ctl_n = 1'b1;
            clear_log();
            go();
            repeat (30) @(negedge clk);
            check(n_str == 0 && !done, "R8", "no cycle with cs_ctl_n high", n_str, 0);
            check(bus_cs_n == 1'b1, "R8", "bus_cs_n follows control", bus_cs_n, 1);
            cs_ctl_n = 1'b0;
            @(negedge clk);
            check(bus_cs_n == 1'b0, "R8", "bus_cs_n low when busy", bus_cs_n, 0);
            wait_done("R8");
            check(n_str == 2, "R8", "beats after release", n_str, 2);
            // write gate
            we_ctl_n = 1'b1;
            clear_log();
            go();
            repeat (30) @(negedge clk);
            check(n_str == 0, "R8", "no write with we_ctl_n high", n_str, 0);
            we_ctl_n = 1'b0;
            wait_done("R8");
            check(n_str == 2, "R8", "beats after write gate", n_str, 2);
        end

        // R9: empty queue stalls
        begin
            automatic int base = tx_idx;
            tx_avail = base;
            set_cfg(0, 2, 0, 3, 0, 0);
            clear_log();
            go();
            repeat (30) @(negedge clk);
            check(n_str == 0 && !done, "R9", "stall on empty", n_str, 0);
            tx_avail = base + 1;
            wait_done("R9");
            check(n_str == 4, "R9", "beats after fill", n_str, 4);
            check(tx_idx == base + 1, "R9", "one pop", tx_idx - base, 1);
            check(beat_v[3] == word_at(base)[31:16] >> 8, "R7", "top byte last", beat_v[3], 16'(word_at(base) >> 24));
        end

        // R10: read mode, 8-bit with partial word, then 16-bit
        for (int m = 0; m < 2; m++) begin
            automatic bit m16 = (m == 1);
            automatic int w = m16 ? 16 : 8;
            automatic int pk = m16 ? 2 : 4;
            automatic int nb = m16 ? 3 : 5;
            automatic int r0 = rd_cnt;
            automatic int base = tx_idx;
            automatic logic [31:0] ex [2];
            ex[0] = 0; ex[1] = 0;
            for (int i = 0; i < nb; i++) begin
                automatic logic [15:0] d = 16'hC3A0 + 16'(r0 + i) * 16'h0111;
                ex[i / pk] |= ((32'(d) & (w == 16 ? 32'hFFFF : 32'hFF)) << ((i % pk) * w));
            end
            tx_avail = base;
            set_cfg(2, 3, m16, nb - 1, 1, 1);
            clear_log();
            go();
            wait_done("R10");
            check(n_str == nb && we_falls == 0, "R10", "read strobes only", n_str, nb);
            check(n_push == 2, "R10", "push count", n_push, 2);
            check(rx_v[0] == ex[0], "R10", "first packed word", rx_v[0], ex[0]);
            check(rx_v[1] == ex[1], "R10", "partial word", rx_v[1], ex[1]);
            check(tx_idx == base, "R10", "no pop in read", tx_idx - base, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule